// File: doc/BRIEF.md
# I2C Controller Mode and Status Tracker

This block holds the mode and status state of an I2C bus controller. A separate bus-level engine does the serial shifting, generates SCL and drives the pins. That engine sends this block one-cycle event strobes: START seen, STOP seen, byte finished (with the last sampled data bit), arbitration lost, own slave address matched, and general-call address matched. Software writes the mode bits and acknowledges interrupts through a write strobe with a data byte. It asks for a START on the bus through a request strobe.

The block packs its state into one readable 8-bit status word. Two bits of that word select one of four modes: master or slave, combined with transmit or receive. The master bit drops by itself in three cases: a STOP is detected, a byte finishes after arbitration was lost, or a START request is refused because another master already holds the bus. A granted START request produces a one-cycle `genStart` pulse toward the engine. A refused request produces a `startBlocked` pulse instead. On a refused request the engine must not issue a START, must not reset its bit counter and must not drive SCL. The interrupt-request bit is active low.

Top module: `i2c_mode_status`

## Requirements
- R1: While reset is held and right after it, `statusWord` reads 0x00, and `genStart` and `startBlocked` are 0.
- R2: The status word bit positions are: bit0 last received bit, bit1 general-call match, bit2 address match, bit3 arbitration lost, bit4 interrupt request (active low), bit5 bus busy, bit6 transmit select, bit7 master select. Bits {7,6} = 00 means slave receive, 01 slave transmit, 10 master receive, 11 master transmit. A software write loads bits 7 and 6 from the data byte. The write leaves bits 0 to 3 and bit 5 unchanged. All updates appear one cycle after the strobe.
- R3: A START strobe sets bus busy. A STOP strobe clears bus busy.
- R4: A STOP strobe clears the master bit. This takes priority over a software write in the same cycle.
- R5: A byte-complete strobe clears the master bit when arbitration lost is set or is being set in the same cycle. Without an arbitration loss, the master bit is kept.
- R6: A byte-complete strobe captures `rxBit` into bit0 and drives bit4 to 0. A software write with bit4 = 1 returns bit4 to 1, and a write with bit4 = 0 leaves it unchanged. In the same cycle, byte-complete wins over the write.
- R7: The arbitration-lost strobe sets bit3. A granted START request clears bit3.
- R8: The address-match and general-call strobes set bits 2 and 1. START and STOP strobes clear both bits. A set strobe in the same cycle as a START or STOP wins.
- R9: A START request with master = 1 and bus busy = 0 gives a one-cycle `genStart` pulse in the next cycle.
- R10: A START request with master = 1 and bus busy = 1 gives no `genStart`. Instead it gives a one-cycle `startBlocked` pulse and clears the master bit.
- R11: A START request with master = 0 is ignored: no pulse, and the status word is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | START condition detected on the bus |
| evStop | input | 1 | STOP condition detected on the bus |
| evByteDone | input | 1 | One byte transfer finished |
| rxBit | input | 1 | Last data bit sampled, valid with evByteDone |
| evArbLost | input | 1 | Arbitration lost detected |
| evAddrMatch | input | 1 | Own slave address matched |
| evGenCall | input | 1 | General-call address matched |
| swWrEn | input | 1 | Software write strobe |
| swWrData | input | 8 | Software write data, in status word layout |
| startReq | input | 1 | Software request to generate START |
| statusWord | output | 8 | Packed status and mode word |
| genStart | output | 1 | Pulse: engine shall generate START |
| startBlocked | output | 1 | Pulse: START suppressed, no counter reset, no SCL drive |

## Verification
The bench targets same-cycle collisions. A STOP arriving together with a master write must leave the master bit clear; a design that ranks the write higher would leave a stray master request behind. A byte-complete arriving together with an interrupt acknowledge must leave the request pending; getting this wrong loses an interrupt. An address match arriving together with a START must survive the START's flag clearing. The bench also sends a START request while the bus is already busy. A design without the duplication guard would pulse `genStart` there and keep master mode, which would collide with the other master. A design that lets the master bit survive a byte lost to arbitration would go on clocking a bus it no longer owns.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int STAT_W  = 8;
  localparam int LRB_POS = 0;
  localparam int GC_POS  = 1;
  localparam int AAS_POS = 2;
  localparam int AL_POS  = 3;
  localparam int IRQ_POS = 4;
  localparam int BB_POS  = 5;
  localparam int TRX_POS = 6;
  localparam int MST_POS = 7;

  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic clrMaster;
    logic loadMode;
    logic loadLrb;
    logic raiseIrq;
    logic releaseIrq;
    logic setAl;
    logic clrAl;
    logic clrMatch;
    logic setAas;
    logic setGc;
    logic issueStart;
    logic blockStart;
  } ctrlStrobes_t;
endpackage

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2c_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByteDone,
  input  logic              evArbLost,
  input  logic              evAddrMatch,
  input  logic              evGenCall,
  input  logic              swWrEn,
  input  logic [STAT_W-1:0] swWrData,
  input  logic              startReq,
  input  logic              masterQ,
  input  logic              busyQ,
  input  logic              alQ,
  output ctrlStrobes_t      strobes
);
  logic startGrant;
  logic startRefuse;
  logic alActive;

  // a request only counts in master mode; busy bus means another master won
  assign startGrant  = startReq & masterQ & ~busyQ;
  assign startRefuse = startReq & masterQ & busyQ;
  assign alActive    = alQ | evArbLost;

  always_comb begin
    strobes            = '0;
    strobes.setBusy    = evStart;
    strobes.clrBusy    = evStop;
    strobes.clrMaster  = evStop | (evByteDone & alActive) | startRefuse;
    strobes.loadMode   = swWrEn;
    strobes.loadLrb    = evByteDone;
    strobes.raiseIrq   = evByteDone;
    strobes.releaseIrq = swWrEn & swWrData[IRQ_POS];
    strobes.setAl      = evArbLost;
    strobes.clrAl      = startGrant;
    strobes.clrMatch   = evStart | evStop;
    strobes.setAas     = evAddrMatch;
    strobes.setGc      = evGenCall;
    strobes.issueStart = startGrant;
    strobes.blockStart = startRefuse;
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    evStart && !evStop |=> busyQ); // R3

  AST_STOP_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> !busyQ && !masterQ); // R4

  AST_LOST_BYTE_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    evByteDone && alQ |=> !masterQ); // R5

  AST_GUARD_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rstN)
    startReq && masterQ && busyQ |=> !masterQ); // R10
endmodule

// File: rtl/i2c_mode_dpath.sv
module i2c_mode_dpath
  import i2c_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [STAT_W-1:0] swWrData,
  input  logic              rxBit,
  output logic [STAT_W-1:0] statusWord,
  output logic              masterQ,
  output logic              busyQ,
  output logic              alQ,
  output logic              genStart,
  output logic              startBlocked
);
  logic trxQ;
  logic lrbQ;
  logic irqNQ;
  logic aasQ;
  logic gcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterQ      <= 1'b0;
      trxQ         <= 1'b0;
      busyQ        <= 1'b0;
      lrbQ         <= 1'b0;
      irqNQ        <= 1'b0;
      alQ          <= 1'b0;
      aasQ         <= 1'b0;
      gcQ          <= 1'b0;
      genStart     <= 1'b0;
      startBlocked <= 1'b0;
    end else begin
      if (strobes.clrBusy)       busyQ <= 1'b0;
      else if (strobes.setBusy)  busyQ <= 1'b1;

      if (strobes.clrMaster)     masterQ <= 1'b0;
      else if (strobes.loadMode) masterQ <= swWrData[MST_POS];

      if (strobes.loadMode)      trxQ <= swWrData[TRX_POS];
      if (strobes.loadLrb)       lrbQ <= rxBit;

      if (strobes.raiseIrq)        irqNQ <= 1'b0;
      else if (strobes.releaseIrq) irqNQ <= 1'b1;

      if (strobes.setAl)         alQ <= 1'b1;
      else if (strobes.clrAl)    alQ <= 1'b0;

      if (strobes.setAas)        aasQ <= 1'b1;
      else if (strobes.clrMatch) aasQ <= 1'b0;

      if (strobes.setGc)         gcQ <= 1'b1;
      else if (strobes.clrMatch) gcQ <= 1'b0;

      genStart     <= strobes.issueStart;
      startBlocked <= strobes.blockStart;
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[LRB_POS] = lrbQ;
    statusWord[GC_POS]  = gcQ;
    statusWord[AAS_POS] = aasQ;
    statusWord[AL_POS]  = alQ;
    statusWord[IRQ_POS] = irqNQ;
    statusWord[BB_POS]  = busyQ;
    statusWord[TRX_POS] = trxQ;
    statusWord[MST_POS] = masterQ;
  end

  AST_BYTE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    strobes.raiseIrq |=> !statusWord[IRQ_POS]); // R6

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({genStart, startBlocked})); // R10

  AST_START_ON_FREE_BUS: assert property (@(posedge clk) disable iff (!rstN)
    genStart |-> $past(masterQ) && !$past(busyQ)); // R9

  AST_AL_SET_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setAl |=> statusWord[AL_POS]); // R7
endmodule

// File: rtl/i2c_mode_status.sv
module i2c_mode_status
  import i2c_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evByteDone,
  input  logic              rxBit,
  input  logic              evArbLost,
  input  logic              evAddrMatch,
  input  logic              evGenCall,
  input  logic              swWrEn,
  input  logic [STAT_W-1:0] swWrData,
  input  logic              startReq,
  output logic [STAT_W-1:0] statusWord,
  output logic              genStart,
  output logic              startBlocked
);
  ctrlStrobes_t strobes;
  logic masterQ;
  logic busyQ;
  logic alQ;

  i2c_mode_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .evStart     (evStart),
    .evStop      (evStop),
    .evByteDone  (evByteDone),
    .evArbLost   (evArbLost),
    .evAddrMatch (evAddrMatch),
    .evGenCall   (evGenCall),
    .swWrEn      (swWrEn),
    .swWrData    (swWrData),
    .startReq    (startReq),
    .masterQ     (masterQ),
    .busyQ       (busyQ),
    .alQ         (alQ),
    .strobes     (strobes)
  );

  i2c_mode_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .swWrData     (swWrData),
    .rxBit        (rxBit),
    .statusWord   (statusWord),
    .masterQ      (masterQ),
    .busyQ        (busyQ),
    .alQ          (alQ),
    .genStart     (genStart),
    .startBlocked (startBlocked)
  );
endmodule

// File: tb/i2c_mode_status_bench.sv
`timescale 1ns/1ps
module i2c_mode_status_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       evStart = 1'b0, evStop = 1'b0, evByteDone = 1'b0, rxBit = 1'b0;
  logic       evArbLost = 1'b0, evAddrMatch = 1'b0, evGenCall = 1'b0;
  logic       swWrEn = 1'b0, startReq = 1'b0;
  logic [7:0] swWrData = 8'h00;
  logic [7:0] statusWord;
  logic       genStart, startBlocked;

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 1'b0;

  localparam int E_START = 1;
  localparam int E_STOP  = 2;
  localparam int E_BYTE  = 4;
  localparam int E_RX    = 8;
  localparam int E_AL    = 16;
  localparam int E_AAS   = 32;
  localparam int E_GC    = 64;
  localparam int E_WR    = 128;
  localparam int E_REQ   = 256;

  typedef struct {
    logic [7:0] word;
    logic       gs;
    logic       blk;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;

  i2c_mode_status u_i2c_mode_status (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evStop(evStop),
    .evByteDone(evByteDone), .rxBit(rxBit), .evArbLost(evArbLost),
    .evAddrMatch(evAddrMatch), .evGenCall(evGenCall), .swWrEn(swWrEn),
    .swWrData(swWrData), .startReq(startReq), .statusWord(statusWord),
    .genStart(genStart), .startBlocked(startBlocked)
  );

  task automatic step(input int ev, input logic [7:0] wd, input logic [7:0] expW,
                      input logic expGs, input logic expBlk, input string tag);
    expItem_t it;
    @(negedge clk);
    evStart     = (ev & E_START) != 0;
    evStop      = (ev & E_STOP) != 0;
    evByteDone  = (ev & E_BYTE) != 0;
    rxBit       = (ev & E_RX) != 0;
    evArbLost   = (ev & E_AL) != 0;
    evAddrMatch = (ev & E_AAS) != 0;
    evGenCall   = (ev & E_GC) != 0;
    swWrEn      = (ev & E_WR) != 0;
    startReq    = (ev & E_REQ) != 0;
    swWrData    = wd;
    it.word = expW; it.gs = expGs; it.blk = expBlk; it.tag = tag;
    expQ.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      testsRun++;
      if (statusWord !== it.word || genStart !== it.gs || startBlocked !== it.blk) begin
        testsFailed++;
        $display("FAIL %s: got word=%02h gs=%b blk=%b expected word=%02h gs=%b blk=%b",
                 it.tag, statusWord, genStart, startBlocked, it.word, it.gs, it.blk);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testsRun++;
    if (statusWord !== 8'h00 || genStart !== 1'b0 || startBlocked !== 1'b0) begin
      testsFailed++;
      $display("FAIL R1 in reset: got word=%02h gs=%b blk=%b expected 00 0 0",
               statusWord, genStart, startBlocked);
    end
    rstN = 1'b1;
    step(0, 8'h00, 8'h00, 0, 0, "R1 after reset");
    step(E_WR, 8'hFF, 8'hD0, 0, 0, "R2 write ignores bits 0-3,5");
    step(E_WR, 8'h40, 8'h50, 0, 0, "R6 write 0 to irq no effect");
    step(E_REQ, 8'h00, 8'h50, 0, 0, "R11 request in slave mode");
    step(E_WR, 8'h80, 8'h90, 0, 0, "R2 master receive");
    step(E_REQ, 8'h00, 8'h90, 1, 0, "R9 start granted");
    step(E_START, 8'h00, 8'hB0, 0, 0, "R3 start sets busy");
    step(E_AAS, 8'h00, 8'hB4, 0, 0, "R8 address match");
    step(E_GC, 8'h00, 8'hB6, 0, 0, "R8 general call");
    step(E_AL, 8'h00, 8'hBE, 0, 0, "R7 arbitration lost");
    step(E_BYTE | E_RX, 8'h00, 8'h2F, 0, 0, "R5 lost byte drops master");
    step(0, 8'h00, 8'h2F, 0, 0, "R6 irq stays pending");
    step(E_STOP, 8'h00, 8'h09, 0, 0, "R3 R8 stop");
    step(E_WR, 8'h90, 8'h99, 0, 0, "R6 irq released");
    step(E_REQ, 8'h00, 8'h91, 1, 0, "R7 grant clears al");
    step(E_START, 8'h00, 8'hB1, 0, 0, "R3 busy again");
    step(E_BYTE, 8'h00, 8'hA0, 0, 0, "R5 clean byte keeps master");
    step(E_BYTE | E_RX | E_WR, 8'h90, 8'hA1, 0, 0, "R6 byte beats release");
    step(E_REQ, 8'h00, 8'h21, 0, 1, "R10 duplication guard");
    step(E_START | E_AAS, 8'h00, 8'h25, 0, 0, "R8 set beats clear");
    step(E_STOP | E_WR, 8'h80, 8'h01, 0, 0, "R4 stop beats write");
    step(E_WR, 8'hC0, 8'hC1, 0, 0, "R2 master transmit");
    step(E_STOP, 8'h00, 8'h41, 0, 0, "R4 stop clears master");
    step(0, 8'h00, 8'h41, 0, 0, "R9 no stray pulse");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule